// File: doc/BRIEF.md
# Programmable Phase-Skew Clock Bank

This block is an all-digital model of a bank of four clock output pairs. It runs on a fast tick clock whose rate is a fixed multiple, `PERIOD`, of the output clock rate. A free-running phase counter marks out one output period. In normal operation the reference is the counter's own square wave: high for the first half of the period and low for the second. Each pair outputs a copy of that reference. The copy can be moved earlier or later by a whole number of time units, divided by two or four, or inverted. A negative skew is an early tap of the same period, taken modulo `PERIOD`.

Each pair is set by two three-level selects, each coded on two bits. A range select sets the size of the time unit, and an edge-polarity input picks which reference edge the outputs align to. A stop input parks outputs at a fixed level. One pair is exempt from it, so that pair can keep serving as a feedback clock. Stopping and restarting happen only when the running waveform already sits at the park level, so no short pulse is produced. A test-mode select gives two further modes. One turns the stop into a per-pair disable. The other, bypass, takes the external reference input in place of the internal phase.

Top module: `skew_clock_bank`

## Requirements
- R1: While reset is held, and from the first tick after it, every pair set to zero skew with polarity high drives 11. The phase counter wraps to 0 after tick PERIOD-1. A zero-skew pair is high for ticks 0 to PERIOD/2-1 of every period, with ticks counted from reset release.
- R2: A level is coded L=00, M=01, H=10, and 11 reads as M (undriven). A pair setting is {first level, second level}, and its index is 3*first+second, from LL=0 to HH=8. MM (0101) is zero skew.
- R3: Pairs 1 and 2 take skew = index-4 time units. At tick n the output is high exactly when ((n-D) mod PERIOD) < PERIOD/2, where D = (skew*tU + h) mod PERIOD, and h = 0 for polarity high.
- R4: On pairs 3 and 4, indices 1 to 7 take skew = 2*(index-4) time units, with the same waveform rule as R3.
- R5: The time unit tU is PERIOD/32 for range 00, PERIOD/16 for range 01 or 11, and PERIOD/8 for range 10.
- R6: Pair 3 divides by 2 at index 0 and by 4 at index 8. Pair 4 divides by 2 at index 0. A 2-bit count c, 0 at reset, steps one tick after each active reference edge. The divide-by-2 output is c[0] and the divide-by-4 output is c[0] xor c[1]. In normal mode the active edge is the tick where the phase is 0 (polarity high) or PERIOD/2 (polarity low).
- R7: At index 8, pair 4 is inverted. At tick n it is high exactly when ((n-h) mod PERIOD) >= PERIOD/2.
- R8: Polarity low sets h = PERIOD/2 for every skewed and inverted output and moves the active edge to the falling reference edge. The divide-by-2 and divide-by-4 outputs then rise in the same tick.
- R9: Outside test mode M, a high stop input asks pairs 1, 3 and 4 to park, and pair 2 keeps running. The park level is low, except for pair 4 in inverted mode, which parks at the polarity level.
- R10: A pair enters or leaves park only after a tick in which the output it would otherwise drive equals its park level. Every high pulse of a skewed output is therefore exactly PERIOD/2 ticks long.
- R11: In test mode M (01 or 11) with the stop input high, every pair at index 0, pair 2 included, parks low. All other pairs run with their settings.
- R12: In test mode 10 (bypass), the source is the reference input. A skewed output at tick n equals the reference input at tick n-D, and D=0 means the same tick. The inverted output is the complement of the reference delayed by h. The active edge is a tick whose reference value has risen (polarity high) or fallen (polarity low) relative to the previous tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, PERIOD ticks per output period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | External reference, used in bypass |
| range_sel | input | 2 | Time-unit range level |
| edge_pol | input | 1 | 1 aligns to the rising reference edge, 0 to the falling edge |
| soe | input | 1 | Stop request for the outputs |
| test_mode | input | 2 | Level: L normal, M per-pair disable, H bypass |
| cfg1 | input | 4 | Pair 1 setting {first, second} |
| cfg2 | input | 4 | Pair 2 setting |
| cfg3 | input | 4 | Pair 3 setting |
| cfg4 | input | 4 | Pair 4 setting |
| q1 | output | 2 | Pair 1 outputs |
| q2 | output | 2 | Pair 2 outputs |
| q3 | output | 2 | Pair 3 outputs |
| q4 | output | 2 | Pair 4 outputs |

## Verification
The bench builds the bank with PERIOD=32, so the time unit is 1, 2 or 4 ticks and a full output period lasts 32 ticks. At that size the bench can sweep all nine settings on every pair, under all four range codes and both polarities, over four periods each. This covers every divider phase and the largest skews of plus and minus six units. The short period also keeps the 31-tap bypass delay line small enough to drive with a pseudo-random reference across every tap, and lets irregular stop windows land at many different phases to expose any runt pulse.

// File: rtl/skew_clock_bank.sv
`timescale 1ns/1ps
module skew_clock_bank #(
  parameter int PERIOD = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_in,
  input  logic [1:0] range_sel,
  input  logic       edge_pol,
  input  logic       soe,
  input  logic [1:0] test_mode,
  input  logic [3:0] cfg1,
  input  logic [3:0] cfg2,
  input  logic [3:0] cfg3,
  input  logic [3:0] cfg4,
  output logic [1:0] q1,
  output logic [1:0] q2,
  output logic [1:0] q3,
  output logic [1:0] q4
);
  localparam int PW   = $clog2(PERIOD);
  localparam int HALF = PERIOD / 2;

  logic [PW-1:0]     ph;
  logic [PERIOD-1:1] hist;
  logic [PERIOD-1:0] taps;
  logic [1:0]        cnt;
  logic              bypass, mid_test, ev;
  int                tu, hoff;
  logic [3:0]        cfg [4];
  wire  [3:0]        live, park, req;
  logic [3:0]        st, qv;

  assign taps     = {hist, ref_in};
  assign bypass   = test_mode == 2'b10;
  assign mid_test = test_mode[0];
  assign hoff     = edge_pol ? 0 : HALF;
  assign cfg[0]   = cfg1;
  assign cfg[1]   = cfg2;
  assign cfg[2]   = cfg3;
  assign cfg[3]   = cfg4;

  always_comb begin
    case (range_sel)
      2'b00:   tu = PERIOD / 32;
      2'b10:   tu = PERIOD / 8;
      default: tu = PERIOD / 16;
    endcase
  end

  function automatic int level(input logic [1:0] c);
    case (c)
      2'b00:   return 0;
      2'b10:   return 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic tap_at(input int d, input logic [PW-1:0] p,
                                  input logic [PERIOD-1:0] t, input logic byp);
    int pd;
    pd = (int'(p) - d + PERIOD) % PERIOD;
    return byp ? t[d[PW-1:0]] : (pd < HALF);
  endfunction

  assign ev = bypass ? (edge_pol ? (ref_in & ~hist[1]) : (~ref_in & hist[1]))
                     : (ph == (edge_pol ? PW'(0) : PW'(HALF)));

  for (genvar i = 0; i < 4; i++) begin : g_pair
    int   idx, sk, dly;
    logic lv, pk, rq;
    always_comb begin
      idx = 3 * level(cfg[i][3:2]) + level(cfg[i][1:0]);
      pk  = 1'b0;
      if (i < 2) sk = idx - 4;
      else       sk = 2 * (idx - 4);
      dly = (sk * tu + hoff + 2 * PERIOD) % PERIOD;
      lv  = tap_at(dly, ph, taps, bypass);
      if (i >= 2 && idx == 0)       lv = cnt[0];
      else if (i == 2 && idx == 8)  lv = cnt[0] ^ cnt[1];
      else if (i == 3 && idx == 8) begin
        lv = ~tap_at(hoff, ph, taps, bypass);
        pk = edge_pol;
      end
      rq = mid_test ? (soe && idx == 0) : (soe && i != 1);
    end
    assign live[i] = lv;
    assign park[i] = pk;
    assign req[i]  = rq;

    // R10
    park_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st[i] != $past(st[i])) |-> $past(qv[i] == park[i]));
  end

  assign qv = (st & park) | (~st & live);
  assign q1 = {2{qv[0]}};
  assign q2 = {2{qv[1]}};
  assign q3 = {2{qv[2]}};
  assign q4 = {2{qv[3]}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= '0;
      hist <= '0;
      cnt  <= '0;
      st   <= '0;
    end else begin
      ph   <= ph + 1'b1;
      hist <= {hist[PERIOD-2:1], ref_in};
      cnt  <= cnt + {1'b0, ev};
      for (int k = 0; k < 4; k++)
        if (st[k] != req[k] && live[k] == park[k]) st[k] <= req[k];
    end
  end

  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PW'(PERIOD - 1)) |=> (ph == '0));

  // R6
  div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> $past(ev));

  // R8
  div_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt[0] ^ cnt[1]) |-> $rose(cnt[0]));
endmodule

// File: tb/tb_skew_clock_bank.sv
`timescale 1ns/1ps
module tb_skew_clock_bank;
  localparam int P = 32;

  logic       clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0, edge_pol = 1'b1, soe = 1'b0;
  logic [1:0] range_sel = 2'b01, test_mode = 2'b00;
  logic [3:0] cfg [4];
  logic [1:0] q1, q2, q3, q4;

  int   checks = 0, errors = 0, k = 0;
  logic [1:0] mc = 2'b00;
  logic mst [4];
  logic rh [P];
  bit   lfsr_on = 0, done = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit   mon_en = 0, mseen = 0;
  logic mprev = 1'b1;
  int   mrun = 0;

  always #2.5 clk = ~clk;

  skew_clock_bank #(.PERIOD(P)) dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .range_sel(range_sel),
    .edge_pol(edge_pol), .soe(soe), .test_mode(test_mode),
    .cfg1(cfg[0]), .cfg2(cfg[1]), .cfg3(cfg[2]), .cfg4(cfg[3]),
    .q1(q1), .q2(q2), .q3(q3), .q4(q4));

  function automatic int lvl(logic [1:0] c);
    return (c == 2'b00) ? 0 : (c == 2'b10) ? 2 : 1;
  endfunction

  function automatic logic [1:0] lcode(int v, bit alt);
    return (v == 0) ? 2'b00 : (v == 2) ? 2'b10 : (alt ? 2'b11 : 2'b01);
  endfunction

  function automatic logic [3:0] enc(int idx, bit alt);
    return {lcode(idx / 3, alt), lcode(idx % 3, alt)};
  endfunction

  function automatic logic [1:0] qget(int p);
    case (p)
      0: return q1;
      1: return q2;
      2: return q3;
      default: return q4;
    endcase
  endfunction

  function automatic logic dl(int d, int ph, bit byp);
    if (byp) return (d == 0) ? ref_in : rh[d-1];
    return (((ph - d + P) % P) < P / 2);
  endfunction

  task automatic chk(string tag, int p, logic [1:0] got, logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s pair %0d tick %0d actual=%b expected=%b", tag, p + 1, k, got, exp);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s tick %0d actual=%0d expected=%0d", tag, k, act, exp);
    end
  endtask

  task automatic step(string ptag);
    int ph, tu, h, idx, sk, d, kind;
    logic lv, pk, rq, ev, ex, qb;
    logic nst [4];
    bit byp, mid;
    string tg;
    #1;
    ph  = k % P;
    byp = (test_mode == 2'b10);
    mid = (test_mode == 2'b01) || (test_mode == 2'b11);
    tu  = (range_sel == 2'b00) ? P / 32 : (range_sel == 2'b10) ? P / 8 : P / 16;
    h   = edge_pol ? 0 : P / 2;
    for (int p = 0; p < 4; p++) begin
      idx  = 3 * lvl(cfg[p][3:2]) + lvl(cfg[p][1:0]);
      kind = 0;
      if (p >= 2 && idx == 0) kind = 1;
      if (p == 2 && idx == 8) kind = 2;
      if (p == 3 && idx == 8) kind = 3;
      sk = (p < 2) ? idx - 4 : 2 * (idx - 4);
      d  = ((sk * tu + h) % P + P) % P;
      case (kind)
        0: lv = dl(d, ph, byp);
        1: lv = mc[0];
        2: lv = mc[0] ^ mc[1];
        default: lv = !dl(h, ph, byp);
      endcase
      pk = (kind == 3) ? edge_pol : 1'b0;
      rq = mid ? (soe && idx == 0) : (soe && p != 1);
      ex = mst[p] ? pk : lv;
      if (ptag != "") tg = ptag;
      else if (kind == 0) tg = (p < 2) ? "R3" : "R4";
      else if (kind == 3) tg = "R7";
      else tg = "R6";
      chk(tg, p, qget(p), {ex, ex});
      nst[p] = (mst[p] != rq && lv == pk) ? rq : mst[p];
    end
    ev = byp ? (edge_pol ? (ref_in && !rh[0]) : (!ref_in && rh[0])) : (ph == h);
    if (mon_en) begin
      qb = q1[0];
      if (qb) begin
        if (!mprev) begin mrun = 1; mseen = 1; end
        else mrun++;
      end else if (mprev && mseen) chk_int("R10", mrun, P / 2);
      mprev = qb;
    end
    @(posedge clk);
    k++;
    if (ev) mc = mc + 2'b01;
    for (int j = P - 1; j > 0; j--) rh[j] = rh[j-1];
    rh[0] = ref_in;
    for (int p = 0; p < 4; p++) mst[p] = nst[p];
    @(negedge clk);
    if (lfsr_on) begin
      lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ref_in = lfsr[0];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lens [6];
    lens = '{37, 21, 50, 9, 70, 44};
    for (int p = 0; p < 4; p++) begin cfg[p] = enc(4, 0); mst[p] = 1'b0; end
    for (int j = 0; j < P; j++) rh[j] = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    for (int p = 0; p < 4; p++) chk("R1", p, qget(p), 2'b11);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2 * P) step("R1");

    for (int a = 0; a < 2; a++) begin
      edge_pol = (a == 0);
      for (int rs = 0; rs < 4; rs++) begin
        range_sel = 2'(rs);
        for (int j = 0; j < 9; j++) begin
          cfg[0] = enc(j, rs == 3);
          cfg[1] = enc((j + 4) % 9, rs == 3);
          cfg[2] = enc(j, rs == 3);
          cfg[3] = enc((j + 6) % 9, rs == 3);
          repeat (4 * P) step(rs == 3 ? "R2" : (a == 1 ? "R8" : ""));
        end
      end
    end

    edge_pol = 1'b1;
    for (int p = 1; p < 4; p++) cfg[p] = enc(4, 0);
    cfg[0] = enc(8, 0);
    for (int rs = 0; rs < 3; rs++) begin
      range_sel = (rs == 0) ? 2'b00 : (rs == 1) ? 2'b01 : 2'b10;
      repeat (2 * P) step("R5");
    end

    range_sel = 2'b01;
    cfg[0] = enc(7, 0); cfg[1] = enc(5, 0); cfg[2] = enc(2, 0); cfg[3] = enc(8, 0);
    for (int a = 0; a < 2; a++) begin
      edge_pol = (a == 0);
      soe = 1'b0;
      repeat (2 * P) step("R9");
      mon_en = 1; mseen = 0; mprev = 1'b1;
      for (int w = 0; w < 6; w++) begin
        soe = (w % 2 == 0);
        repeat (lens[w]) step("R9");
      end
      soe = 1'b0;
      repeat (2 * P) step("R9");
      mon_en = 0;
    end

    edge_pol = 1'b1;
    test_mode = 2'b01; soe = 1'b1;
    cfg[0] = enc(5, 0); cfg[1] = enc(0, 0); cfg[2] = enc(0, 0); cfg[3] = enc(3, 0);
    repeat (3 * P) step("R11");
    test_mode = 2'b11;
    cfg[0] = enc(0, 0); cfg[1] = enc(4, 0); cfg[2] = enc(8, 0); cfg[3] = enc(0, 0);
    repeat (3 * P) step("R11");
    soe = 1'b0;
    repeat (2 * P) step("R11");

    test_mode = 2'b10; lfsr_on = 1;
    for (int a = 0; a < 2; a++) begin
      edge_pol = (a == 0);
      for (int rs = 0; rs < 2; rs++) begin
        range_sel = (rs == 0) ? 2'b00 : 2'b10;
        for (int j = 0; j < 9; j++) begin
          cfg[0] = enc(j, 0);
          cfg[1] = enc((j + 4) % 9, 0);
          cfg[2] = enc(j, 0);
          cfg[3] = enc((j + 6) % 9, 0);
          repeat (2 * P) step("R12");
        end
      end
    end
    soe = 1'b1;
    repeat (P) step("R12");
    soe = 1'b0;
    repeat (P) step("R12");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule